// File: doc/BRIEF.md
# Double-Buffered Programmable Frequency Divider

This block divides an incoming clock-rate event stream by a programmable 15-bit ratio. A fixed front-end stage first produces one advance tick every eight input clocks. A presettable down-counter then runs on those ticks. Each time it reaches zero it raises a single-clock pulse and reloads itself. A toggle flop gives a half-rate square wave of that pulse train, which is meant for routing to a test observation point.

A controller writes a new ratio at any moment. The write lands in a holding register. The counter's preload register is updated from the holding register only at the counter's terminal count, so a write never shortens or stretches a division period that is already running. A written ratio becomes the counter's period starting at the second terminal count after the write. Ratios below the legal floor are raised to the floor as they pass into the preload register. After reset the divider runs with a ratio of 256.

Top module: `prog_ratio_divider`

## Requirements
- R1: While reset is asserted and right after it, `div_pulse` and `div_half` are 0. With no write, consecutive pulses are 256 x 8 = 2048 clocks apart.
- R2: With a preload ratio N, `div_pulse` rises once every N x 8 clock cycles.
- R3: Every `div_pulse` assertion lasts exactly one clock cycle.
- R4: A write with `wr_en` high stores `wr_ratio` in the holding register. It has no effect on the length of the period in progress, nor on the period that starts at the next terminal count.
- R5: The holding register is copied into the preload register only at a terminal count. The written ratio governs the period that begins at the second terminal count after the write.
- R6: A written ratio below 17, including 0, is applied as 17.
- R7: The ratio is the plain binary value of `wr_ratio`, with bit 0 as the least significant bit and bit 14 as the most significant bit. The legal range is 17 to 32767.
- R8: `div_half` inverts in the cycle that `div_pulse` is high and holds its value otherwise. It is therefore a square wave with a period of 2N x 8 clocks.
- R9: The down-counter advances only on the prescaler tick. The tick comes once every 8 clocks, so no period is shorter than 17 x 8 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Loads `wr_ratio` into the holding register |
| wr_ratio | input | 15 | New division ratio, binary, bit 0 = LSB |
| div_pulse | output | 1 | One-clock pulse at each terminal count |
| div_half | output | 1 | Divider output divided by two |

## Verification
The divider is first left at its reset ratio, which shows the power-on default and the prescale factor together. A write placed right after a pulse is then followed across three periods. The first two must keep the old length and only the third may change, which separates a correct two-stage transfer from a single-stage one or a direct load. Writes of 5 and 0 show the floor clamp. Writes of 85 and 300 have scattered set bits, which exposes bit-order and width mistakes. A cycle-by-cycle behavioural model is compared with both outputs on every clock throughout the run.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    localparam int unsigned RATIO_W_DEF  = 15;
    localparam int unsigned PRESCALE_DEF = 8;
    localparam int unsigned MIN_RATIO    = 17;
    localparam int unsigned POWERON_RATIO = 256;
endpackage

// File: rtl/fdiv_prescaler.sv
module fdiv_prescaler #(
    parameter int unsigned PRESCALE = fdiv_pkg::PRESCALE_DEF
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (PRESCALE <= 1) begin : g_bypass
            assign tick = 1'b1;
        end else begin : g_count
            localparam int unsigned PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

            typedef struct packed {
                logic [PW-1:0] cnt;
            } pre_st_t;

            pre_st_t s_d, s_q;

            always_comb begin
                s_d = s_q;
                if (s_q.cnt == LAST) s_d.cnt = '0;
                else                 s_d.cnt = s_q.cnt + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= s_d;
            end

            assign tick = (s_q.cnt == LAST);

            // R9: ticks are never back to back when prescaling is active
            p_tick_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/fdiv_ratio_latch.sv
module fdiv_ratio_latch #(
    parameter int unsigned RATIO_W   = fdiv_pkg::RATIO_W_DEF,
    parameter int unsigned MIN_RATIO = fdiv_pkg::MIN_RATIO,
    parameter int unsigned DEF_RATIO = fdiv_pkg::POWERON_RATIO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RATIO_W-1:0] wr_ratio,
    input  logic               xfer,
    output logic [RATIO_W-1:0] ratio_b
);
    localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_RATIO);
    localparam logic [RATIO_W-1:0] INIT  = RATIO_W'(DEF_RATIO);

    typedef struct packed {
        logic [RATIO_W-1:0] hold_a;
        logic [RATIO_W-1:0] pre_b;
    } lat_st_t;

    lat_st_t s_d, s_q;
    logic [RATIO_W-1:0] clamped;

    always_comb begin
        clamped = (s_q.hold_a < FLOOR) ? FLOOR : s_q.hold_a;
        s_d = s_q;
        if (wr_en) s_d.hold_a = wr_ratio;
        if (xfer)  s_d.pre_b  = clamped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.hold_a <= INIT;
            s_q.pre_b  <= INIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign ratio_b = s_q.pre_b;

    // R6: the preload register never holds a ratio below the floor
    p_b_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pre_b >= FLOOR);
    // R5: preload register only changes on a transfer
    p_b_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(s_q.pre_b));
    // R4: holding register only changes on a write
    p_a_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q.hold_a));
endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter #(
    parameter int unsigned RATIO_W = fdiv_pkg::RATIO_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [RATIO_W-1:0] ratio_b,
    output logic               xfer,
    output logic               div_pulse,
    output logic               div_half
);
    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic               pulse;
        logic               half;
    } cnt_st_t;

    cnt_st_t s_d, s_q;
    logic    at_zero;

    always_comb begin
        at_zero = (s_q.cnt == '0);
        xfer    = tick && at_zero;
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (tick) begin
            if (at_zero) begin
                s_d.cnt   = ratio_b - 1'b1;
                s_d.pulse = 1'b1;
                s_d.half  = ~s_q.half;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign div_pulse = s_q.pulse;
    assign div_half  = s_q.half;

    // R3: the output pulse is one clock wide
    p_pulse_one_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);
    // R8: half-rate output flips exactly with the pulse
    p_half_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (div_half != $past(div_half)));
    p_half_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(div_half));
    // R9: the counter only moves on a prescaler tick
    p_cnt_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q.cnt));
endmodule

// File: rtl/prog_ratio_divider.sv
module prog_ratio_divider #(
    parameter int unsigned RATIO_W   = fdiv_pkg::RATIO_W_DEF,
    parameter int unsigned PRESCALE  = fdiv_pkg::PRESCALE_DEF,
    parameter int unsigned MIN_RATIO = fdiv_pkg::MIN_RATIO,
    parameter int unsigned DEF_RATIO = fdiv_pkg::POWERON_RATIO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RATIO_W-1:0] wr_ratio,
    output logic               div_pulse,
    output logic               div_half
);
    logic               tick;
    logic               xfer;
    logic [RATIO_W-1:0] ratio_b;

    fdiv_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    fdiv_ratio_latch #(
        .RATIO_W   (RATIO_W),
        .MIN_RATIO (MIN_RATIO),
        .DEF_RATIO (DEF_RATIO)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ratio (wr_ratio),
        .xfer     (xfer),
        .ratio_b  (ratio_b)
    );

    fdiv_counter #(.RATIO_W(RATIO_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ratio_b   (ratio_b),
        .xfer      (xfer),
        .div_pulse (div_pulse),
        .div_half  (div_half)
    );

    // R5: a transfer only happens on a prescaler tick
    p_xfer_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> tick);
endmodule

// File: tb/test_prog_ratio_divider.sv
module test_prog_ratio_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [14:0] wr_ratio = '0;
    logic        div_pulse, div_half;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    prog_ratio_divider i_prog_ratio_divider (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ratio(wr_ratio),
        .div_pulse(div_pulse), .div_half(div_half)
    );

    // behavioural reference: integers only
    int m_pre = 0, m_left = 0, m_a = 256, m_b = 256;
    bit m_p = 0, m_h = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_pre = 0; m_left = 0; m_a = 256; m_b = 256; m_p = 0; m_h = 0;
        end else begin
            int next_a;
            next_a = wr_en ? int'(wr_ratio) : m_a;
            m_p = 0;
            if (m_pre == 7) begin
                if (m_left == 0) begin
                    m_p = 1;
                    m_h = !m_h;
                    m_left = m_b - 1;
                    m_b = (m_a < 17) ? 17 : m_a;
                end else begin
                    m_left--;
                end
                m_pre = 0;
            end else begin
                m_pre++;
            end
            m_a = next_a;
        end
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        total++;
        if (div_pulse !== m_p || div_half !== m_h) begin
            bad++;
            $display("FAIL %s model: actual=%b%b expected=%b%b", tag, div_pulse, div_half, m_p, m_h);
        end
    end

    task automatic check(input string t, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!div_pulse);
    endtask

    // measures the clocks to the next pulse, starting at a pulse; checks width and half toggle
    task automatic period(output int n);
        bit h0;
        h0 = div_half;
        n = 0;
        @(negedge clk); n++;
        check("R3 pulse width", int'(div_pulse), 0);
        while (!div_pulse) begin @(negedge clk); n++; end
        check("R8 half toggles", int'(div_half), int'(!h0));
    endtask

    task automatic write_now(input int r);
        wr_ratio = 15'(r); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // write just after a pulse, then return the length of the third period
    task automatic apply(input int r, output int p1, output int p2, output int p3);
        wait_pulse();
        write_now(r);
        wait_pulse();
        period(p1);
        period(p2);
        period(p3);
    endtask

    initial begin
        int p, a1, a2, a3;
        repeat (3) @(negedge clk);
        check("R1 reset pulse", int'(div_pulse), 0);
        check("R1 reset half", int'(div_half), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset pulse", int'(div_pulse), 0);
        wait_pulse();
        period(p);
        check("R1 default period", p, 2048);

        tag = "R4";
        wait_pulse();
        write_now(20);
        p = 0;
        // period that was running during the write
        while (!div_pulse) begin @(negedge clk); p++; end
        check("R4 running period", p + 1, 2048);
        period(p);
        check("R5 period after first tc", p, 2048);
        tag = "R2";
        period(p);
        check("R2 new ratio 20", p, 160);

        tag = "R6";
        apply(5, a1, a2, a3);
        check("R6 clamp 5", a3, 136);
        apply(0, a1, a2, a3);
        check("R6 clamp 0", a3, 136);
        check("R9 minimum period", a3, 17 * 8);

        tag = "R7";
        apply(85, a1, a2, a3);
        check("R7 ratio 85", a3, 680);
        apply(300, a1, a2, a3);
        check("R7 ratio 300", a3, 2400);
        check("R5 old ratio kept", a1, 680);

        tag = "R8";
        period(p);
        check("R8 steady period", p, 2400);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule